// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Programming Controller

A behavioural, synthesizable model of a byte-wide one-time-programmable memory. It has two uses. In normal operation it serves reads: an address and an active-low select go in, and one clock later a registered data byte comes out together with an output-enable flag. That flag stands in for a high-impedance output stage. While the memory is deselected, a registered standby flag shows that it would be in its low-power state. Selecting it again clears the flag with no wake-up delay.

Raising the programming-mode input gives the same pins a second meaning. A latch strobe stores the upper address bits, which are taken from the lowest address lines. The full programming address is those stored bits joined to address lines 0 to 7. Two active-low strobes then select the operation. Program alone pulled low writes the cell. Verify alone pulled low reads the cell back, which also serves as a blank check. Both high is inhibit, in which the data outputs are released. Both low is an illegal combination: it sets a sticky fault flag and writes nothing.

Every cell leaves reset erased, at all ones. Programming can only clear bits. The production instance uses ADDR_W = 13, giving 8192 words and five latched upper bits. The default configuration is ADDR_W = 11, giving 2048 words and three latched upper bits, which keeps elaboration small.

Top module: `promRom`

## Requirements
- R1: During and directly after reset, dataOe, standby and strobeErr are 0, and every cell reads 8'hFF.
- R2: When progEn is 0 and csN is 0 at a clock edge, dataOut holds mem[addrIn] and dataOe is 1 after that edge.
- R3: When progEn is 0 and csN is 1 at a clock edge, dataOe is 0 and dataOut is 8'h00 after that edge.
- R4: When progEn is 1, a high latchStb at an edge stores addrIn[ADDR_W-9:0] as the upper address bits. Every programming operation uses the address {stored upper bits, addrIn[7:0]}.
- R5: When progEn is 1, pgmN is 0 and vfyN is 1, the addressed cell becomes its old value AND dataIn, and dataOe is 0 after the edge.
- R6: When progEn is 1, pgmN is 1 and vfyN is 0, dataOut holds the addressed cell and dataOe is 1 after the edge. This covers both verify and blank check.
- R7: When progEn is 1 and pgmN and vfyN are both 1 (inhibit), dataOe is 0 after the edge and no cell changes.
- R8: When progEn is 1 and pgmN and vfyN are both 0, strobeErr becomes 1 and stays 1 until reset. No cell changes and dataOe is 0.
- R9: standby is 1 after an edge at which progEn is 0 and csN is 1. It is 0 after any other edge.
- R10: In read mode (progEn 0), the program and verify strobes have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; erases the array |
| addrIn | input | ADDR_W | Read address; in programming mode, the upper-bit source and low address |
| csN | input | 1 | Active-low select for reads |
| progEn | input | 1 | Programming-mode enable |
| latchStb | input | 1 | Stores the upper address bits (programming mode) |
| pgmN | input | 1 | Active-low program strobe |
| vfyN | input | 1 | Active-low verify strobe |
| dataIn | input | DATA_W | Data to program |
| dataOut | output | DATA_W | Registered read or verify data; 0 when disabled |
| dataOe | output | 1 | Output-enable flag (0 means high impedance) |
| standby | output | 1 | Deselected low-power indication |
| strobeErr | output | 1 | Sticky flag for an illegal strobe combination |

## Verification
Every word of the default array is swept three times: once through a blank read, once through programming followed by verify, and once through a normal read. The programmed data comes from an arithmetic pattern of the address. Any fault in joining the latched upper bits to the low address therefore shows up as a data mismatch. A second programming pass over every fifth word, with a different pattern, separates AND-style bit clearing from plain overwriting. Separate directed stimuli cover the remaining cases. Inhibit, illegal strobes and strobes in read mode are each followed by a read-back, which shows that none of them changed a cell. A final reset confirms that the fault flag clears and the cells return to the erased state.

// File: rtl/promPkg.sv
package promPkg;
  // Strobes from the control unit to the storage array
  typedef struct packed {
    logic wrEn;   // AND the input byte into the addressed cell
    logic rdEn;   // load the addressed cell onto the outputs
  } promCtlT;
endpackage

// File: rtl/promCtl.sv
module promCtl
  import promPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              csN,
  input  logic              progEn,
  input  logic              latchStb,
  input  logic              pgmN,
  input  logic              vfyN,
  output promCtlT           ctl,
  output logic [ADDR_W-1:0] memAddr,
  output logic              standby,
  output logic              strobeErr
);
  localparam int UP_W = ADDR_W - LOW_W;

  logic [UP_W-1:0] upperQ;
  logic            badStrobes;

  assign badStrobes = progEn && !pgmN && !vfyN;

  always_comb begin
    ctl     = '0;
    memAddr = addrIn;
    if (progEn) begin
      memAddr = {upperQ, addrIn[LOW_W-1:0]};
      case ({pgmN, vfyN})
        2'b01:   ctl.wrEn = 1'b1;
        2'b10:   ctl.rdEn = 1'b1;
        default: ctl      = '0;
      endcase
    end else begin
      ctl.rdEn = !csN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ    <= '0;
      standby   <= 1'b0;
      strobeErr <= 1'b0;
    end else begin
      if (progEn && latchStb) upperQ <= addrIn[UP_W-1:0];
      standby <= !progEn && csN;
      if (badStrobes) strobeErr <= 1'b1;
    end
  end
endmodule

// File: rtl/promArray.sv
module promArray
  import promPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  promCtlT           ctl,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      if (ctl.wrEn) cells[memAddr] <= cells[memAddr] & dataIn;
      if (ctl.rdEn) begin
        dataOut <= cells[memAddr];
        dataOe  <= 1'b1;
      end else begin
        dataOut <= '0;
        dataOe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/promRom.sv
module promRom
  import promPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              csN,
  input  logic              progEn,
  input  logic              latchStb,
  input  logic              pgmN,
  input  logic              vfyN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              standby,
  output logic              strobeErr
);
  localparam int LOW_W = 8;

  promCtlT           ctl;
  logic [ADDR_W-1:0] memAddr;

  promCtl #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) uCtl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .csN(csN), .progEn(progEn),
    .latchStb(latchStb), .pgmN(pgmN), .vfyN(vfyN), .ctl(ctl),
    .memAddr(memAddr), .standby(standby), .strobeErr(strobeErr)
  );

  promArray #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uArray (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memAddr(memAddr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/promChk.sv
module promChk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic progEn,
  input logic pgmN,
  input logic vfyN,
  input logic dataOe,
  input logic standby,
  input logic strobeErr
);
  a_r2_select_enables: assert property (@(posedge clk) disable iff (!rstN)
    (!progEn && !csN) |=> dataOe);
  a_r3_deselect_floats: assert property (@(posedge clk) disable iff (!rstN)
    (!progEn && csN) |=> !dataOe);
  a_r5_program_floats: assert property (@(posedge clk) disable iff (!rstN)
    (progEn && !pgmN && vfyN) |=> !dataOe);
  a_r6_verify_drives: assert property (@(posedge clk) disable iff (!rstN)
    (progEn && pgmN && !vfyN) |=> dataOe);
  a_r7_inhibit_floats: assert property (@(posedge clk) disable iff (!rstN)
    (progEn && pgmN && vfyN) |=> !dataOe);
  a_r8_fault_sets: assert property (@(posedge clk) disable iff (!rstN)
    (progEn && !pgmN && !vfyN) |=> (strobeErr && !dataOe));
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    strobeErr |=> strobeErr);
  a_r9_standby_on: assert property (@(posedge clk) disable iff (!rstN)
    (!progEn && csN) |=> standby);
  a_r9_standby_off: assert property (@(posedge clk) disable iff (!rstN)
    (progEn || !csN) |=> !standby);
endmodule

bind promRom promChk uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .progEn(progEn), .pgmN(pgmN),
  .vfyN(vfyN), .dataOe(dataOe), .standby(standby), .strobeErr(strobeErr)
);

// File: tb/tb_promRom.sv
module tb_promRom;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int LW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN, csN, progEn, latchStb, pgmN, vfyN;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataIn, dataOut;
  logic          dataOe, standby, strobeErr;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;
  logic [DW-1:0] expMem [DEPTH];

  always #2 clk = ~clk;

  promRom #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .csN(csN), .progEn(progEn),
    .latchStb(latchStb), .pgmN(pgmN), .vfyN(vfyN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .standby(standby), .strobeErr(strobeErr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patA(int a);
    return DW'((a * 29 + 7) ^ (a >> 4));
  endfunction

  function automatic logic [DW-1:0] patB(int a);
    return DW'(a ^ 8'hC3);
  endfunction

  // programming-mode helper: latch upper bits, then present the low address
  task automatic setPgmAddr(int a);
    progEn   = 1'b1;
    addrIn   = AW'(a >> LW);
    latchStb = 1'b1;
    tick();
    latchStb = 1'b0;
    addrIn   = AW'(a & 255);
  endtask

  task automatic progWord(int a, logic [DW-1:0] v);
    setPgmAddr(a);
    dataIn = v;
    pgmN   = 1'b0;
    tick();
    chk("R5 oe during program", 32'(dataOe), 0);
    pgmN = 1'b1;
  endtask

  task automatic verWord(int a, logic [DW-1:0] exp, string req);
    setPgmAddr(a);
    vfyN = 1'b0;
    tick();
    chk(req, 32'(dataOut), 32'(exp));
    chk("R6 oe during verify", 32'(dataOe), 1);
    vfyN = 1'b1;
  endtask

  task automatic readWord(int a, logic [DW-1:0] exp, string req);
    progEn = 1'b0;
    csN    = 1'b0;
    addrIn = AW'(a);
    tick();
    chk(req, 32'(dataOut), 32'(exp));
    chk("R2 oe on select", 32'(dataOe), 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; progEn = 1'b0; latchStb = 1'b0;
    pgmN = 1'b1; vfyN = 1'b1; addrIn = '0; dataIn = '0;
    repeat (3) tick();
    rstN = 1'b1;
    // R1: reset state
    chk("R1 oe", 32'(dataOe), 0);
    chk("R1 standby", 32'(standby), 0);
    chk("R1 strobeErr", 32'(strobeErr), 0);
    for (int a = 0; a < DEPTH; a++) begin
      expMem[a] = 8'hFF;
      readWord(a, 8'hFF, "R1 erased cell");
    end

    // R3 / R9: deselect then reselect
    csN = 1'b1;
    tick();
    chk("R3 oe off", 32'(dataOe), 0);
    chk("R3 data zero", 32'(dataOut), 0);
    chk("R9 standby on", 32'(standby), 1);
    csN = 1'b0;
    tick();
    chk("R9 standby off", 32'(standby), 0);

    // R5/R4: program every word, then verify and read back
    for (int a = 0; a < DEPTH; a++) begin
      progWord(a, patA(a));
      expMem[a] = expMem[a] & patA(a);
    end
    chk("R9 standby off in program mode", 32'(standby), 0);
    for (int a = 0; a < DEPTH; a++) verWord(a, expMem[a], "R4 R6 verify data");
    for (int a = 0; a < DEPTH; a++) readWord(a, expMem[a], "R2 R4 read data");

    // R5: second pass clears bits only (AND)
    for (int a = 0; a < DEPTH; a += 5) begin
      progWord(a, patB(a));
      expMem[a] = expMem[a] & patB(a);
    end
    for (int a = 0; a < DEPTH; a += 5) verWord(a, expMem[a], "R5 and-programming");

    // R7: inhibit leaves cells and floats outputs
    setPgmAddr(100);
    dataIn = 8'h00;
    tick();
    chk("R7 oe in inhibit", 32'(dataOe), 0);
    verWord(100, expMem[100], "R7 cell unchanged");

    // R10: strobes in read mode do nothing
    progEn = 1'b0;
    csN = 1'b0;
    addrIn = AW'(200);
    dataIn = 8'h00;
    pgmN = 1'b0;
    tick();
    pgmN = 1'b1;
    vfyN = 1'b0;
    tick();
    vfyN = 1'b1;
    readWord(200, expMem[200], "R10 cell unchanged");
    csN = 1'b1;
    tick();
    chk("R3 oe off again", 32'(dataOe), 0);

    // R8: illegal strobe pair
    setPgmAddr(300);
    dataIn = 8'h00;
    pgmN = 1'b0;
    vfyN = 1'b0;
    tick();
    chk("R8 strobeErr set", 32'(strobeErr), 1);
    chk("R8 oe off", 32'(dataOe), 0);
    pgmN = 1'b1;
    vfyN = 1'b1;
    tick();
    tick();
    chk("R8 strobeErr sticky", 32'(strobeErr), 1);
    verWord(300, expMem[300], "R8 no write");

    // R1: reset clears flag and erases
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    chk("R1 strobeErr cleared", 32'(strobeErr), 0);
    readWord(300, 8'hFF, "R1 erased after reset");
    readWord(0, 8'hFF, "R1 erased after reset");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule